// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block folds the exception outcome of one floating-point operation into a 32-bit status word. The caller presents the current status word together with a 5-bit set of raised IEEE exception flags and a one-cycle valid strobe. One clock later the block returns the updated status word and a trap request.

Inside the status word the block uses four fields: a trap enable mask, an accrued exception field, a current exception field and a trap type field. An operation traps when any raised flag also has its enable bit set. When a trap is taken, only one flag is reported: the highest-priority enabled flag. The accrued field is left alone in that case.

When no trap is taken, the raised flags become the current field and are also ORed into the accrued field. A small two-state controller drives the output strobe. In ST_IDLE it waits. On a strobe it captures the result and moves to ST_EMIT, where the result is presented for one cycle. From ST_EMIT it returns to ST_IDLE, unless another strobe arrives, in which case it stays in ST_EMIT and presents the new result.

Top module: `fxr_recorder`

## Requirements
- R1: After reset, out_valid and out_trap are low and out_status is zero.
- R2: A strobe on in_valid at a clock edge produces out_valid high during the following cycle. Strobes on consecutive cycles give out_valid on consecutive cycles. With no strobe, out_valid is low one cycle later.
- R3: Field positions in the status word are: enable mask bits 27:23, accrued field bits 9:5, current field bits 4:0, trap type bits 16:14. Within every 5-bit field the flag order is invalid bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1, inexact bit 0.
- R4: out_trap is high with out_valid exactly when (in_flags AND enable mask) was nonzero.
- R5: On a trap, the current field holds only the highest-priority enabled raised flag. The priority order is invalid, overflow, underflow, divide-by-zero, inexact.
- R6: Without a trap, the current field equals in_flags.
- R7: Without a trap, the accrued field becomes old accrued OR in_flags. On a trap, the accrued field is unchanged.
- R8: The trap type field is cleared for every recorded operation. It is then set to 1 (IEEE exception) when a trap is taken.
- R9: All status bits outside the current, accrued and trap type fields pass through unchanged.
- R10: With in_flags zero, the current field is cleared, no trap is raised and the accrued field keeps its value.
- R11: While out_valid is low, out_status and out_trap keep the value of the last recorded operation. out_trap is additionally forced low while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation result strobe |
| in_status | input | 32 | Status word before the operation |
| in_flags | input | 5 | Raised exception flags |
| out_valid | output | 1 | Updated word is present |
| out_status | output | 32 | Updated status word |
| out_trap | output | 1 | Trap request |

## Verification
Two functions can fall in the same cycle: reducing the flags to one on a trap, and gating the accrued update. Whenever several flags are raised and at least one of them is enabled, both act in that cycle. The bench provokes this with random flag and mask pairs, plus directed cases where all five flags are raised under sparse masks. For each case it checks that the current field is a single flag of the right priority and that the accrued field stayed as it was. Back-to-back strobes that move the controller from ST_EMIT to ST_EMIT are mixed in. This confirms that each cycle reports its own operation.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
    localparam int FLAG_W  = 5;
    localparam int CUR_LSB = 0;
    localparam int ACC_LSB = 5;
    localparam int TT_LSB  = 14;
    localparam int TT_W    = 3;
    localparam int TEM_LSB = 23;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fxr_state_e;
endpackage

// File: rtl/fxr_trap_decide.sv
module fxr_trap_decide
    import fxr_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] enables,
    output logic              trap,
    output logic [FLAG_W-1:0] kept
);
    logic [FLAG_W-1:0] masked;

    assign masked = flags & enables;
    assign trap   = |masked;

    // Highest index has priority: invalid at the top, inexact at the bottom.
    always_comb begin
        kept = '0;
        for (int i = 0; i < FLAG_W; i++) begin
            if (masked[i]) begin
                kept    = '0;
                kept[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fxr_word_build.sv
module fxr_word_build
    import fxr_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] status_in,
    input  logic [FLAG_W-1:0] flags,
    input  logic              trap,
    input  logic [FLAG_W-1:0] kept,
    output logic [STAT_W-1:0] status_out
);
    logic [FLAG_W-1:0] old_acc;

    assign old_acc = status_in[ACC_LSB +: FLAG_W];

    always_comb begin
        status_out = status_in;
        status_out[TT_LSB +: TT_W] = '0;
        if (trap) begin
            status_out[CUR_LSB +: FLAG_W] = kept;
            status_out[TT_LSB +: TT_W]    = TT_IEEE;
        end else begin
            status_out[CUR_LSB +: FLAG_W] = flags;
            status_out[ACC_LSB +: FLAG_W] = old_acc | flags;
        end
    end
endmodule

// File: rtl/fxr_ctrl.sv
module fxr_ctrl
    import fxr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic capture,
    output logic emit
);
    fxr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        capture = in_valid;
        emit    = 1'b0;
        unique case (state_q)
            ST_IDLE: emit = 1'b0;
            ST_EMIT: emit = 1'b1;
            default: emit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fxr_recorder.sv
module fxr_recorder
    import fxr_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [STAT_W-1:0] in_status,
    input  logic [4:0]        in_flags,
    output logic              out_valid,
    output logic [STAT_W-1:0] out_status,
    output logic              out_trap
);
    localparam int TEM_MSB = TEM_LSB + FLAG_W - 1;

    logic              capture, emit, trap_c, trap_q;
    logic [FLAG_W-1:0] kept_c;
    logic [STAT_W-1:0] word_c, word_q;

    fxr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .capture  (capture),
        .emit     (emit)
    );

    fxr_trap_decide u_dec (
        .flags   (in_flags),
        .enables (in_status[TEM_MSB:TEM_LSB]),
        .trap    (trap_c),
        .kept    (kept_c)
    );

    fxr_word_build #(.STAT_W(STAT_W)) u_build (
        .status_in  (in_status),
        .flags      (in_flags),
        .trap       (trap_c),
        .kept       (kept_c),
        .status_out (word_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            trap_q <= 1'b0;
        end else if (capture) begin
            word_q <= word_c;
            trap_q <= trap_c;
        end
    end

    assign out_valid  = emit;
    assign out_status = word_q;
    assign out_trap   = emit & trap_q;
endmodule

// File: rtl/fxr_chk.sv
module fxr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_status,
    input logic [4:0]  in_flags,
    input logic        out_valid,
    input logic [31:0] out_status,
    input logic        out_trap
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    single_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_trap) |-> ($countones(out_status[4:0]) == 1));
    // R4
    no_enabled_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_trap) |-> ((out_status[27:23] & out_status[4:0]) == 5'd0));
    // R7
    acc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_flags & in_status[27:23]) != 5'd0) |=> (out_status[9:5] == $past(in_status[9:5])));
    // R8
    tt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_status[16:14] == {2'b00, out_trap}));
    // R11
    trap_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_trap);
endmodule

bind fxr_recorder fxr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_status  (in_status),
    .in_flags   (in_flags),
    .out_valid  (out_valid),
    .out_status (out_status),
    .out_trap   (out_trap)
);

// File: tb/sim_fxr_recorder.sv
module sim_fxr_recorder;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_status = '0;
    logic [4:0]  in_flags = '0;
    logic        out_valid, out_trap;
    logic [31:0] out_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] last_word;
    logic        last_trap;

    always #(CLK_P/2) clk = ~clk;

    fxr_recorder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_status(in_status),
        .in_flags(in_flags), .out_valid(out_valid), .out_status(out_status),
        .out_trap(out_trap)
    );

    function automatic logic exp_trap(input logic [31:0] s, input logic [4:0] f);
        return (f & s[27:23]) != 5'd0;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] s, input logic [4:0] f);
        logic [31:0] w;
        logic [4:0]  m, one;
        w = s;
        w[16:14] = 3'd0;
        m = f & s[27:23];
        if (m != 0) begin
            one = 5'd0;
            for (int b = 4; b >= 0; b--) begin
                if (m[b] && one == 0) one[b] = 1'b1;
            end
            w[4:0]   = one;
            w[16:14] = 3'd1;
        end else begin
            w[4:0] = f;
            w[9:5] = s[9:5] | f;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check one full cycle later.
    task automatic op(input logic [31:0] s, input logic [4:0] f, input bit keep, input string req);
        in_valid  = 1'b1;
        in_status = s;
        in_flags  = f;
        @(negedge clk);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " trap"},  {31'd0, out_trap},  {31'd0, exp_trap(s, f)});
        check({req, " word"},  out_status, exp_word(s, f));
        last_word = exp_word(s, f);
        last_trap = exp_trap(s, f);
        if (!keep) begin
            in_valid  = 1'b0;
            in_status = $urandom;
            in_flags  = 5'($urandom);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid",  {31'd0, out_valid}, 32'd0);
        check("R1 trap",   {31'd0, out_trap},  32'd0);
        check("R1 status", out_status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R6 no enables: flags land in the current field and accrue
        op({5'b00000, 23'h0, 4'h0} | 32'h0000_0140, 5'b10101, 0, "R6");
        // R10 zero flags: accrued kept, current cleared, type cleared
        op(32'h0001_C3FF, 5'b00000, 0, "R10");
        // R4 R5 all flags, all enabled: invalid wins
        op({5'b11111, 23'h0} | 32'h0000_001F, 5'b11111, 0, "R5 all");
        // R5 sparse mask: overflow disabled, underflow picked
        op({5'b10100, 23'h0} | 32'h0000_0060, 5'b01111, 0, "R5 sparse");
        // R5 only inexact enabled
        op({5'b00001, 23'h0}, 5'b11111, 0, "R5 inexact");
        // R7 trap leaves accrued intact even with other flags raised
        op({5'b00010, 23'h0} | 32'h0000_02A0, 5'b00110, 0, "R7");
        // R9 surrounding bits pass unchanged
        op(32'hF07E_BC00, 5'b01001, 0, "R9");
        // R4 raised flags all disabled: no trap
        op({5'b01010, 23'h0}, 5'b10101, 0, "R4");

        // R11 idle hold
        @(negedge clk);
        check("R11 valid", {31'd0, out_valid}, 32'd0);
        check("R11 trap",  {31'd0, out_trap},  32'd0);
        check("R11 hold",  out_status, last_word);

        // R2 back-to-back strobes plus random patterns
        for (int k = 0; k < 300; k++) begin
            logic [31:0] s;
            logic [4:0]  f;
            s = $urandom;
            f = 5'($urandom);
            if (k % 7 == 0) f = 5'b11111;
            op(s, f, ($urandom % 3) != 0, "R2 R5 R7 rnd");
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 drop", {31'd0, out_valid}, 32'd0);
        check("R11 end hold", out_status, last_word);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule